// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This unit takes two 32-bit operands and adds or subtracts them as signed numbers. It can treat the operands as one 32-bit lane, two 16-bit lanes or four 8-bit lanes. Each lane works on its own, with no carry or borrow into the next lane. Each lane clamps its result to its own signed range. The packed result is captured in an output register, together with one saturation bit per lane.

The unit also keeps a sticky overflow flag. Only the full-width operation can set it; the packed modes never touch it. The flag is cleared or loaded only through a dedicated write port, which stands in for a status-register write.

Operands enter over a valid/ready input channel and leave over a valid/ready output channel. The output holds a single result register. A new operation is accepted while that register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low with a result pending, `in_ready` is low and the result stays frozen. The write port and the flag output are plain signals with no handshake.

Top module: `psat_unit`

## Requirements
- R1: In word mode (`in_mode` = 0), the result is the 32-bit signed sum or difference clamped to [-2^31, 2^31-1].
- R2: In halfword mode (`in_mode` = 1), lane i occupies bits [16i+15:16i]. Each lane is clamped to [-32768, 32767], with no carry between lanes.
- R3: In byte mode (`in_mode` = 2), lane i occupies bits [8i+7:8i]. Each lane is clamped to [-128, 127], with no carry between lanes.
- R4: `in_sub` = 0 selects add and `in_sub` = 1 selects subtract. Subtract computes `in_a` minus `in_b` in every lane.
- R5: Bit i of `out_lane_sat` is 1 when lane i's clamped result differs from its exact result. Bits above the lane count of the mode are 0. The bits are registered together with `out_data`.
- R6: An accepted word-mode operation that saturates sets `q_flag` to 1 on that edge. An accepted word-mode operation that does not saturate leaves `q_flag` unchanged.
- R7: Accepted halfword and byte operations never change `q_flag`, even when lanes saturate.
- R8: `q_flag` changes to 0 only when `q_wr_en` is high, which loads `q_wr_data`. That write wins over a saturating word operation in the same cycle.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_lane_sat` hold their values.
- R10: A synchronous reset clears `out_data`, `out_lane_sat`, `out_valid` and `q_flag` to 0.
- R11: `in_mode` = 3 behaves exactly like word mode, including its effect on `q_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_mode | input | 2 | Lane mode: 0 word, 1 halfword, 2 byte, 3 word |
| in_sub | input | 1 | 0 add, 1 subtract (a minus b) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Packed clamped result |
| out_lane_sat | output | 4 | Per-lane saturation indication |
| q_wr_en | input | 1 | Write strobe for the sticky flag |
| q_wr_data | input | 1 | Value loaded into the sticky flag |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
Inputs are driven on a falling edge. An operation is accepted on the next rising edge when `in_ready` is high. Its `out_data`, `out_lane_sat` and the updated `q_flag` are all due right after that same edge, one register stage later, so the bench samples them on the following falling edge. A flag write lands on the same edge and is sampled at the same point. During a stall, the bench checks over two falling edges that `in_ready` stays low and the pending result does not move. It then checks that the held operation is accepted on the first edge after `out_ready` returns high.

// File: rtl/psat_pkg.sv
package psat_pkg;
  typedef enum logic [1:0] {
    LM_WORD  = 2'd0,
    LM_HALF  = 2'd1,
    LM_BYTE  = 2'd2,
    LM_SPARE = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/psat_lane.sv
module psat_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          sub,
  output logic [LW-1:0] y,
  output logic          sat
);
  localparam logic [LW-1:0] MAX_V = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] MIN_V = {1'b1, {(LW-1){1'b0}}};

  logic [LW:0] ea, eb, ex;

  always_comb begin
    ea  = {a[LW-1], a};
    eb  = {b[LW-1], b};
    ex  = sub ? (ea - eb) : (ea + eb);
    sat = ex[LW] ^ ex[LW-1];
    if (sat) y = ex[LW] ? MIN_V : MAX_V;
    else     y = ex[LW-1:0];
  end

  // A clamped lane always carries the sign of the first operand
  always_comb begin
    if (sat) begin
      // R1
      sat_sign_chk: assert (y[LW-1] == a[LW-1] && y[LW-2:0] == {(LW-1){~a[LW-1]}});
    end
  end
endmodule

// File: rtl/psat_slicer.sv
module psat_slicer #(
  parameter int DW = 32,
  parameter int LW = 8,
  localparam int N = DW / LW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y,
  output logic [N-1:0]  sat
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    psat_lane #(.LW(LW)) u_lane (
      .a   (a[i*LW +: LW]),
      .b   (b[i*LW +: LW]),
      .sub (sub),
      .y   (y[i*LW +: LW]),
      .sat (sat[i])
    );
  end
endmodule

// File: rtl/psat_unit.sv
module psat_unit #(
  parameter int DATA_W = 32,
  localparam int HALF_N = DATA_W / 16,
  localparam int BYTE_N = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic              in_sub,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [BYTE_N-1:0] out_lane_sat,
  input  logic              q_wr_en,
  input  logic              q_wr_data,
  output logic              q_flag
);
  import psat_pkg::*;

  lane_mode_e         mode;
  logic [DATA_W-1:0]  w_y, h_y, b_y, nxt_y;
  logic               w_sat;
  logic [HALF_N-1:0]  h_sat;
  logic [BYTE_N-1:0]  b_sat, nxt_sat;
  logic               fire, word_op;

  assign mode = lane_mode_e'(in_mode);

  psat_slicer #(.DW(DATA_W), .LW(DATA_W)) u_word (
    .a(in_a), .b(in_b), .sub(in_sub), .y(w_y), .sat(w_sat)
  );
  psat_slicer #(.DW(DATA_W), .LW(16)) u_half (
    .a(in_a), .b(in_b), .sub(in_sub), .y(h_y), .sat(h_sat)
  );
  psat_slicer #(.DW(DATA_W), .LW(8)) u_byte (
    .a(in_a), .b(in_b), .sub(in_sub), .y(b_y), .sat(b_sat)
  );

  always_comb begin
    word_op = 1'b0;
    unique case (mode)
      LM_HALF: begin
        nxt_y   = h_y;
        nxt_sat = {{(BYTE_N-HALF_N){1'b0}}, h_sat};
      end
      LM_BYTE: begin
        nxt_y   = b_y;
        nxt_sat = b_sat;
      end
      default: begin
        nxt_y   = w_y;
        nxt_sat = {{(BYTE_N-1){1'b0}}, w_sat};
        word_op = 1'b1;
      end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_lane_sat <= '0;
    end else if (fire) begin
      out_valid    <= 1'b1;
      out_data     <= nxt_y;
      out_lane_sat <= nxt_sat;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         q_flag <= 1'b0;
    else if (q_wr_en)                q_flag <= q_wr_data;
    else if (fire && word_op && w_sat) q_flag <= 1'b1;
  end

  // R8
  q_no_silent_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (q_flag && !q_wr_en) |=> q_flag);

  // R8
  q_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    q_wr_en |=> (q_flag == $past(q_wr_data)));

  // R7
  q_packed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !word_op && !q_wr_en) |=> $stable(q_flag));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_lane_sat)));

  // R5
  sat_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && mode == LM_HALF) |=> (out_lane_sat[BYTE_N-1:HALF_N] == '0));
endmodule

// File: tb/psat_unit_bench.sv
module psat_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_sub, out_valid, out_ready;
  logic [1:0]  in_mode;
  logic [31:0] in_a, in_b, out_data;
  logic [3:0]  out_lane_sat;
  logic        q_wr_en, q_wr_data, q_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit q_model = 1'b0;

  always #5 clk = ~clk;

  psat_unit u_psat_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_sub(in_sub), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_lane_sat(out_lane_sat), .q_wr_en(q_wr_en), .q_wr_data(q_wr_data),
    .q_flag(q_flag)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void lane_model(input int w, input logic [31:0] a, input logic [31:0] b,
                                     input bit sub, output longint r, output bit s);
    longint m, sa, sb, ex;
    m  = longint'(1) << w;
    sa = longint'(a) & (m - 1); if (sa >= m / 2) sa -= m;
    sb = longint'(b) & (m - 1); if (sb >= m / 2) sb -= m;
    ex = sub ? sa - sb : sa + sb;
    s  = 1'b0;
    if (ex > m / 2 - 1)   begin ex = m / 2 - 1; s = 1'b1; end
    else if (ex < -m / 2) begin ex = -m / 2;    s = 1'b1; end
    r = ex & (m - 1);
  endfunction

  function automatic void pack_model(input logic [1:0] mode, input bit sub, input logic [31:0] a,
                                     input logic [31:0] b, output logic [31:0] res, output logic [3:0] sat);
    int w;
    longint acc, r;
    bit s;
    w   = (mode == 2'd1) ? 16 : (mode == 2'd2) ? 8 : 32;
    acc = 0;
    sat = '0;
    for (int i = 0; i < 32 / w; i++) begin
      lane_model(w, a >> (i * w), b >> (i * w), sub, r, s);
      acc |= r << (i * w);
      sat[i] = s;
    end
    res = acc[31:0];
  endfunction

  function automatic string tag_of(input logic [1:0] mode);
    case (mode)
      2'd1: return "R2";
      2'd2: return "R3";
      2'd3: return "R11";
      default: return "R1";
    endcase
  endfunction

  // One accepted operation; result due after the accepting edge, sampled at the next falling edge
  task automatic send(input logic [1:0] mode, input bit sub, input logic [31:0] a, input logic [31:0] b,
                      input bit wr, input bit wrd);
    logic [31:0] er;
    logic [3:0]  es;
    pack_model(mode, sub, a, b, er, es);
    if (wr) q_model = wrd;
    else if ((mode == 2'd0 || mode == 2'd3) && es[0]) q_model = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_sub = sub; in_a = a; in_b = b;
    q_wr_en = wr; q_wr_data = wrd;
    @(negedge clk);
    in_valid = 1'b0; q_wr_en = 1'b0;
    check(tag_of(mode), "data", out_data, er);
    check(sub ? "R4" : "R5", "lane_sat", out_lane_sat, es);
    check(wr ? "R8" : ((mode == 2'd1 || mode == 2'd2) ? "R7" : "R6"), "q_flag", q_flag, q_model);
    check("R9", "out_valid", out_valid, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    int seed_val;
    rst = 1'b1; in_valid = 1'b0; in_mode = 2'd0; in_sub = 1'b0; in_a = '0; in_b = '0;
    out_ready = 1'b1; q_wr_en = 1'b0; q_wr_data = 1'b0;
    seed_val = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "out_data", out_data, 0);
    check("R10", "out_lane_sat", out_lane_sat, 0);
    check("R10", "out_valid", out_valid, 0);
    check("R10", "q_flag", q_flag, 0);
    check("R9", "in_ready", in_ready, 1);
    rst = 1'b0;

    // Directed corners
    send(2'd0, 0, 32'h0000_0005, 32'h0000_0003, 0, 0);   // R1 no sat
    send(2'd1, 0, 32'h7FFF_0001, 32'h0001_FFFF, 0, 0);   // R2/R7 sat high, no carry
    send(2'd2, 1, 32'h807F_0010, 32'h01FF_0020, 0, 0);   // R3/R4 byte sat both ways
    check("R7", "q after packed sat", q_flag, 0);
    send(2'd0, 0, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0);   // R1/R6 clamp high, sets Q
    send(2'd0, 0, 32'h0000_0001, 32'h0000_0001, 0, 0);   // R6 Q stays
    send(2'd0, 1, 32'h8000_0000, 32'h0000_0001, 0, 0);   // R4 clamp low
    send(2'd2, 0, 32'h0000_0000, 32'h0000_0000, 1, 0);   // R8 explicit clear
    send(2'd0, 0, 32'h8000_0000, 32'h8000_0000, 1, 0);   // R8 write wins over sat
    send(2'd3, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0);   // R11 spare code acts as word
    send(2'd1, 1, 32'h8000_7FFF, 32'h0001_FFFF, 1, 1);   // R8 write sets
    send(2'd1, 1, 32'h0000_0000, 32'h8000_8000, 1, 0);

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_mode = 2'd2; in_sub = 1'b0;
    in_a = 32'h1122_3344; in_b = 32'h0101_0101;
    @(negedge clk);
    check("R9", "stall data", out_data, 32'h1223_3445);
    in_a = 32'h7F7F_7F7F; in_b = 32'h7F7F_7F7F;
    check("R9", "in_ready low", in_ready, 0);
    @(negedge clk);
    check("R9", "hold data", out_data, 32'h1223_3445);
    check("R9", "hold valid", out_valid, 1);
    check("R9", "hold sat", out_lane_sat, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "release data", out_data, 32'h7F7F_7F7F);
    check("R5", "release sat", out_lane_sat, 4'hF);
    @(negedge clk);
    check("R9", "drained", out_valid, 0);

    // Constrained random mix
    for (int k = 0; k < 400; k++) begin
      int pick;
      pick = $urandom_range(0, 3);
      ra = $urandom();
      rb = $urandom();
      if (pick == 0) ra = {ra[31], {31{~ra[31]}}};
      if (pick == 1) begin ra = ra & 32'h8080_8080 | 32'h7F00_7F00; rb = rb | 32'h4040_4040; end
      send(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), ra, rb,
           ($urandom_range(0, 15) == 0), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule